// File: doc/BRIEF.md
# Predicate Register File with Commit Guard

This block holds a small file of single-bit predicate registers and uses them to decide whether issued operations may commit. A compare operation evaluates a signed source value against zero in one of four modes. It then writes two predicates in the same cycle: the outcome goes to one destination and its inverse to the other. Operations that are not guarded by a branch carry a predicate index instead. The block looks that index up and raises a commit enable only when the selected bit is set. When the enable is low, the execution pipeline must discard the operation's results.

Entry 0 always reads as one, so operations guarded by it are unconditional, and any write aimed at it is dropped. A compare that reaches a predicate in the same cycle as a guard lookup of that predicate forwards its fresh value to the lookup. A compare whose two destinations are the same is rejected: it is flagged and writes nothing. The file size, the source width, the number of guard ports and the presence of forwarding are all parameters.

Top module: `pred_guard_unit`

## Requirements
- R1: A compare with `cmp_valid` high and distinct destinations writes its outcome to entry `cmp_dst_t` and the inverted outcome to entry `cmp_dst_f`. Both values are visible from the following cycle.
- R2: The `cmp_op` encoding is 0 = source equals zero, 1 = source not zero, 2 = source negative (two's complement MSB set), 3 = source zero or positive.
- R3: Each guard port p drives `gd_commit[p]` high only when `gd_valid[p]` is high and the selected predicate is 1. When `gd_valid[p]` is low, `gd_commit[p]` is 0.
- R4: Entry 0 always reads as 1. A compare destination of 0 is ignored, while the other destination of the same compare is still written.
- R5: A guard lookup in the same cycle as a legal compare that targets the looked-up entry (other than 0) sees the new value.
- R6: `cmp_illegal` is high exactly when `cmp_valid` is high and `cmp_dst_t` equals `cmp_dst_f`. Such a compare changes no entry.
- R7: After reset, every entry reads 0 except entry 0, which reads 1.
- R8: The guard ports operate independently. Port p uses index bits `gd_idx[p*IW +: IW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | Compare operation present this cycle |
| cmp_op | input | 2 | Compare mode (see R2) |
| cmp_src | input | DW | Signed source value compared against zero |
| cmp_dst_t | input | IW | Entry receiving the compare outcome |
| cmp_dst_f | input | IW | Entry receiving the inverted outcome |
| cmp_illegal | output | 1 | Compare rejected because its destinations coincide |
| gd_valid | input | NRD | Guard lookup request per port |
| gd_idx | input | NRD*IW | Packed predicate index per port |
| gd_commit | output | NRD | Commit enable per port |

## Verification
The assertions assume that the compare inputs and guard inputs are known values in every cycle after reset. They also assume that the two write paths never hit the same entry. That is true because an illegal compare is blocked before it writes. The random stimulus drives fully defined values in every cycle. It confines half of the indices to the lowest eight entries so that collisions, forwarding hits and equal destinations occur often. Directed cycles cover entry 0, each compare mode and the rejected compare.

// File: rtl/pred_pkg.sv
package pred_pkg;
   typedef enum logic [1:0] {
      CMP_EQZ = 2'd0,
      CMP_NEZ = 2'd1,
      CMP_LTZ = 2'd2,
      CMP_GEZ = 2'd3
   } cmp_mode_e;
endpackage

// File: rtl/pred_cmp.sv
module pred_cmp #(
   parameter int DW = 32
) (
   input  logic [1:0]    mode,
   input  logic [DW-1:0] src,
   output logic          outcome
);
   import pred_pkg::*;
   logic is_zero, is_neg;

   initial begin
      if (DW < 2) $error("pred_cmp: DW must be at least 2");
   end

   assign is_zero = (src == '0);
   assign is_neg  = src[DW-1];

   always_comb begin
      unique case (cmp_mode_e'(mode))
         CMP_EQZ: outcome = is_zero;
         CMP_NEZ: outcome = !is_zero;
         CMP_LTZ: outcome = is_neg;
         CMP_GEZ: outcome = !is_neg;
         default: outcome = 1'b0;
      endcase
   end
endmodule

// File: rtl/pred_file.sv
module pred_file #(
   parameter int NP = 64,
   localparam int IW = $clog2(NP)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_a,
   input  logic [IW-1:0] idx_a,
   input  logic          val_a,
   input  logic          we_b,
   input  logic [IW-1:0] idx_b,
   input  logic          val_b,
   output logic [NP-1:0] bits_q
);
   assign bits_q[0] = 1'b1;

   genvar i;
   generate
      for (i = 1; i < NP; i++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bits_q[i] <= 1'b0;
            else if (we_a && idx_a == IW'(i))
               bits_q[i] <= val_a;
            else if (we_b && idx_b == IW'(i))
               bits_q[i] <= val_b;
         end
      end
   endgenerate

   AST_ENTRY0_SET: assert property (@(posedge clk) disable iff (!rst_n)
      bits_q[0] == 1'b1); // R4
   AST_A_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      (we_a && idx_a != '0) |=> bits_q[$past(idx_a)] == $past(val_a)); // R1
   AST_B_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      (we_b && idx_b != '0 && !(we_a && idx_a == idx_b))
      |=> bits_q[$past(idx_b)] == $past(val_b)); // R1
endmodule

// File: rtl/pred_guard_port.sv
module pred_guard_port #(
   parameter int NP  = 64,
   parameter bit FWD = 1'b1,
   localparam int IW = $clog2(NP)
) (
   input  logic [NP-1:0] bits_q,
   input  logic          req,
   input  logic [IW-1:0] idx,
   input  logic          wa,
   input  logic [IW-1:0] wa_idx,
   input  logic          wa_val,
   input  logic          wb,
   input  logic [IW-1:0] wb_idx,
   input  logic          wb_val,
   output logic          commit
);
   logic bit_sel;

   generate
      if (FWD) begin : g_fwd
         always_comb begin
            if (wa && idx == wa_idx && idx != '0)
               bit_sel = wa_val;
            else if (wb && idx == wb_idx && idx != '0)
               bit_sel = wb_val;
            else
               bit_sel = bits_q[idx];
         end
      end else begin : g_nofwd
         logic unused_ok;
         assign unused_ok = wa ^ wb ^ wa_val ^ wb_val ^ (^wa_idx) ^ (^wb_idx);
         assign bit_sel = bits_q[idx];
      end
   endgenerate

   assign commit = req && bit_sel;

   always_comb begin
      AST_IDLE_NO_COMMIT: assert (req || !commit); // R3
      if (req && idx == '0)
         AST_ENTRY0_COMMITS: assert (commit); // R4
   end
endmodule

// File: rtl/pred_guard_unit.sv
module pred_guard_unit #(
   parameter int NP  = 64,
   parameter int DW  = 32,
   parameter int NRD = 2,
   parameter bit FWD = 1'b1,
   localparam int IW = $clog2(NP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_valid,
   input  logic [1:0]        cmp_op,
   input  logic [DW-1:0]     cmp_src,
   input  logic [IW-1:0]     cmp_dst_t,
   input  logic [IW-1:0]     cmp_dst_f,
   output logic              cmp_illegal,
   input  logic [NRD-1:0]    gd_valid,
   input  logic [NRD*IW-1:0] gd_idx,
   output logic [NRD-1:0]    gd_commit
);
   logic          outcome;
   logic          wr_ok, we_t, we_f;
   logic [NP-1:0] bits_q;

   initial begin
      if (NP < 2 || (1 << IW) != NP) $error("pred_guard_unit: NP must be a power of two >= 2");
      if (NRD < 1) $error("pred_guard_unit: NRD must be >= 1");
   end

   pred_cmp #(.DW(DW)) u_cmp (
      .mode(cmp_op), .src(cmp_src), .outcome(outcome)
   );

   assign cmp_illegal = cmp_valid && (cmp_dst_t == cmp_dst_f);
   assign wr_ok = cmp_valid && !cmp_illegal;
   assign we_t  = wr_ok && cmp_dst_t != '0;
   assign we_f  = wr_ok && cmp_dst_f != '0;

   pred_file #(.NP(NP)) u_file (
      .clk(clk), .rst_n(rst_n),
      .we_a(we_t), .idx_a(cmp_dst_t), .val_a(outcome),
      .we_b(we_f), .idx_b(cmp_dst_f), .val_b(!outcome),
      .bits_q(bits_q)
   );

   genvar p;
   generate
      for (p = 0; p < NRD; p++) begin : g_port
         pred_guard_port #(.NP(NP), .FWD(FWD)) u_port (
            .bits_q(bits_q), .req(gd_valid[p]), .idx(gd_idx[p*IW +: IW]),
            .wa(we_t), .wa_idx(cmp_dst_t), .wa_val(outcome),
            .wb(we_f), .wb_idx(cmp_dst_f), .wb_val(!outcome),
            .commit(gd_commit[p])
         );
      end
   endgenerate

   AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_illegal |=> bits_q == $past(bits_q)); // R6
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |=> bits_q == $past(bits_q)); // R1
   AST_PAIR_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && cmp_dst_t != '0 && cmp_dst_f != '0)
      |=> bits_q[$past(cmp_dst_t)] != bits_q[$past(cmp_dst_f)]); // R1
endmodule

// File: tb/sim_pred_guard_unit.sv
module sim_pred_guard_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NP  = 64;
   localparam int DW  = 32;
   localparam int NRD = 2;
   localparam int IW  = $clog2(NP);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmp_valid = 1'b0;
   logic [1:0]        cmp_op = '0;
   logic [DW-1:0]     cmp_src = '0;
   logic [IW-1:0]     cmp_dst_t = '0;
   logic [IW-1:0]     cmp_dst_f = '0;
   logic              cmp_illegal;
   logic [NRD-1:0]    gd_valid = '0;
   logic [NRD*IW-1:0] gd_idx = '0;
   logic [NRD-1:0]    gd_commit;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [NP-1:0] model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pred_guard_unit #(.NP(NP), .DW(DW), .NRD(NRD), .FWD(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
      .cmp_src(cmp_src), .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
      .cmp_illegal(cmp_illegal), .gd_valid(gd_valid), .gd_idx(gd_idx),
      .gd_commit(gd_commit)
   );

   function automatic logic f_outcome(logic [1:0] op, logic [DW-1:0] s);
      case (op)
         2'd0: return s == '0;
         2'd1: return s != '0;
         2'd2: return s[DW-1];
         default: return !s[DW-1];
      endcase
   endfunction

   function automatic logic f_legal();
      return rst_n && cmp_valid && cmp_dst_t != cmp_dst_f;
   endfunction

   function automatic logic f_commit(logic v, logic [IW-1:0] idx);
      logic r;
      r = f_outcome(cmp_op, cmp_src);
      if (!v) return 1'b0;
      if (idx == '0) return 1'b1;
      if (f_legal() && idx == cmp_dst_t) return r;
      if (f_legal() && idx == cmp_dst_f) return !r;
      return model[idx];
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic check_cycle(string forced);
      string tag;
      chk(forced == "" ? "R6" : forced, cmp_illegal, rst_n && cmp_valid && cmp_dst_t == cmp_dst_f);
      for (int p = 0; p < NRD; p++) begin
         logic [IW-1:0] ix;
         ix = gd_idx[p*IW +: IW];
         if (forced != "") tag = forced;
         else if (!gd_valid[p]) tag = "R3";
         else if (ix == '0) tag = "R4";
         else if (f_legal() && (ix == cmp_dst_t || ix == cmp_dst_f)) tag = "R5";
         else if (p != 0) tag = "R8";
         else tag = "R1";
         chk(tag, gd_commit[p], f_commit(gd_valid[p], ix));
      end
   endtask

   task automatic commit_model();
      logic r;
      r = f_outcome(cmp_op, cmp_src);
      if (f_legal()) begin
         if (cmp_dst_t != '0) model[cmp_dst_t] = r;
         if (cmp_dst_f != '0) model[cmp_dst_f] = !r;
      end
   endtask

   task automatic step(logic v, logic [1:0] op, logic [DW-1:0] s,
                       logic [IW-1:0] dt, logic [IW-1:0] df,
                       logic [NRD-1:0] gv, logic [NRD*IW-1:0] gi, string tag);
      @(negedge clk);
      cmp_valid = v; cmp_op = op; cmp_src = s; cmp_dst_t = dt; cmp_dst_f = df;
      gd_valid = gv; gd_idx = gi;
      #1;
      check_cycle(tag);
      commit_model();
   endtask

   function automatic logic [IW-1:0] rnd_idx();
      if ($urandom_range(1) == 0) return IW'($urandom_range(7));
      return IW'($urandom_range(NP-1));
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] vals [4];
      void'($urandom(32'd20240611));
      // R7: reset state, check every entry through port 0
      #2;
      for (int k = 0; k < NP; k++) begin
         gd_valid = 2'b01; gd_idx = '0; gd_idx[IW-1:0] = IW'(k);
         #1;
         chk("R7", gd_commit[0], k == 0);
      end
      @(negedge clk); rst_n = 1'b1;

      // R1: write pair, then read both on two ports (R8)
      step(1, 2'd0, '0, 6'd5, 6'd6, 2'b00, '0, "R1");
      step(0, 2'd0, '0, 6'd0, 6'd0, 2'b11, {6'd6, 6'd5}, "R1");
      // R4: destination 0 ignored, other side still written
      step(1, 2'd0, 32'd1, 6'd0, 6'd9, 2'b00, '0, "R4");
      step(0, 2'd0, '0, 6'd0, 6'd0, 2'b11, {6'd9, 6'd0}, "R4");
      // R6: equal destinations rejected, entry 9 keeps 1
      step(1, 2'd0, '0, 6'd9, 6'd9, 2'b01, {6'd0, 6'd9}, "R6");
      step(0, 2'd0, '0, 6'd0, 6'd0, 2'b01, {6'd0, 6'd9}, "R6");
      // R5: same-cycle forwarding on both destinations
      step(1, 2'd1, 32'd7, 6'd12, 6'd13, 2'b11, {6'd13, 6'd12}, "R5");
      // R3: no request, no commit even for entry 0
      step(0, 2'd0, '0, 6'd0, 6'd0, 2'b00, {6'd0, 6'd12}, "R3");
      // R2: each mode against zero, positive, negative sources
      vals[0] = '0; vals[1] = 32'd3; vals[2] = 32'h8000_0000; vals[3] = 32'hFFFF_FFFF;
      for (int m = 0; m < 4; m++) begin
         for (int v = 0; v < 4; v++) begin
            step(1, 2'(m), vals[v], 6'd20, 6'd21, 2'b11, {6'd21, 6'd20}, "R2");
            step(0, 2'd0, '0, 6'd0, 6'd0, 2'b11, {6'd21, 6'd20}, "R2");
         end
      end
      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic [IW-1:0] dt;
         logic [IW-1:0] df;
         dt = rnd_idx();
         df = ($urandom_range(9) == 0) ? dt : rnd_idx();
         step($urandom_range(2) != 0, 2'($urandom_range(3)),
              ($urandom_range(3) == 0) ? '0 : DW'($urandom()),
              dt, df, NRD'($urandom_range(3)), {rnd_idx(), rnd_idx()}, "");
      end
      // R7: reset again clears entries
      @(negedge clk); rst_n = 1'b0; cmp_valid = 1'b0; model = '0;
      #1;
      gd_valid = 2'b11; gd_idx = {6'd20, 6'd9};
      #1;
      chk("R7", gd_commit[0], 1'b0);
      chk("R7", gd_commit[1], 1'b0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule